// File: doc/BRIEF.md
# Burst Column Address Generator

This block turns one accepted memory access into the stream of column addresses that a synchronous DRAM burst walks through. When a start strobe arrives it captures the first column, a burst-length code and an order select. From the next clock it presents one column address per accepted beat, and it flags the final beat of a fixed-length burst. Row and bank selection, data handling, read-latency alignment and command encoding are left to neighbouring logic.

Fixed bursts of 1, 2, 4 or 8 beats stay inside the naturally aligned block of that size that holds the start column. Inside that block the beats either count upward and wrap (linear order) or visit the start column XORed with the beat index (interleaved order). A page-length burst counts upward through the whole row. It wraps from the top column to column 0, and it ends only when the stop strobe or a new start strobe arrives.

The address output is a valid/ready stream. A beat is consumed on a clock edge where `col_valid_o` and `col_ready_i` are both high. While the consumer holds `col_ready_i` low, the address and the last-beat flag are held and the burst does not advance. `col_ready_i` has no effect while `col_valid_o` is low. The start and stop strobes are plain single-cycle controls and do not wait for the handshake.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, `col_valid_o` and `last_o` are low.
- R2: A cycle with `start_i` high captures `start_col_i`, `len_code_i` and `ilv_i`. In the following cycle `col_valid_o` is high and `col_o` equals the captured column.
- R3: The 3-bit `len_code_i` is decoded as follows: 0 is 1 beat, 1 is 2 beats, 2 is 4 beats, 3 is 8 beats, and 7 is a page-length burst. Codes 4, 5 and 6 behave as 1 beat.
- R4: In a fixed burst of length BL with `ilv_i` = 0, beat k carries the start column's bits above log2(BL) unchanged. Its low log2(BL) bits are (start + k) mod BL. For example, with BL=4 and start offset 1 the order is 1,2,3,0.
- R5: In a fixed burst with `ilv_i` = 1, beat k keeps the same upper bits, and its low log2(BL) bits are the start offset XOR k. For example, with BL=4 and start offset 1 the order is 1,0,3,2.
- R6: In a page-length burst, beat k is (start + k) mod 2^COL_W. The burst wraps from the top column to 0, never asserts `last_o`, never ends on its own, and ignores `ilv_i`.
- R7: `last_o` is high exactly on the final beat of a fixed burst. After that beat is accepted, `col_valid_o` is low in the next cycle unless a new start arrives.
- R8: While `col_valid_o` is high and `col_ready_i` is low, `col_o` and `last_o` hold their values and the beat index does not advance.
- R9: `stop_i` without `start_i` ends any burst: `col_valid_o` and `last_o` are low in the next cycle.
- R10: `start_i` during an active burst abandons it and restarts from the new column in the next cycle. `start_i` takes priority over `stop_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe; captures the burst setup |
| start_col_i | input | COL_W | First column of the burst |
| len_code_i | input | 3 | Burst-length code (see R3) |
| ilv_i | input | 1 | 1 selects interleaved order for fixed bursts |
| stop_i | input | 1 | Terminate strobe |
| col_ready_i | input | 1 | Consumer accepts the current beat |
| col_valid_o | output | 1 | Current column address is valid |
| col_o | output | COL_W | Column address of the current beat |
| last_o | output | 1 | Current beat is the final beat of a fixed burst |

## Verification
The sweep covers every length code in both orders, from every start offset inside an 8-column block and from columns near the top of the row. This exposes a design that lets the carry escape the aligned block, or that applies XOR to the wrong bits, because such a design would print a column outside the block or in the wrong order. Bursts are repeated under a periodic back-pressure pattern, which catches a generator that advances or changes `last_o` while stalled. A long page burst that starts just below the top column checks three things: the wrap to 0, that `last_o` is never raised, and that an interleave request is ignored. Directed cases cover a stop in the middle of a burst, a restart in the middle of a burst, and start and stop arriving together, where a wrong priority would leave the stream idle.

// File: rtl/burst_pkg.sv
package burst_pkg;

  localparam int LG_W = 2;

  typedef struct packed {
    logic            page;
    logic            ilv;
    logic [LG_W-1:0] lg;
  } burst_cfg_t;

  function automatic burst_cfg_t decode_len(input logic [2:0] code, input logic ilv);
    burst_cfg_t c;
    c.page = 1'b0;
    c.ilv  = ilv;
    c.lg   = '0;
    case (code)
      3'd1:    c.lg = 2'd1;
      3'd2:    c.lg = 2'd2;
      3'd3:    c.lg = 2'd3;
      3'd7: begin
        c.page = 1'b1;
        c.ilv  = 1'b0;
      end
      default: c.lg = 2'd0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/burst_cfg_reg.sv
module burst_cfg_reg import burst_pkg::*; #(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [2:0]       len_code_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] base_o,
  output logic [COL_W-1:0] mask_o,
  output logic             page_o,
  output logic             ilv_o
);

  localparam int MAX_FIXED_BITS = 1 << LG_W;

  burst_cfg_t       cfg_q;
  logic [COL_W-1:0] base_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      base_q <= '0;
    end else if (load_i) begin
      cfg_q  <= decode_len(len_code_i, ilv_i);
      base_q <= col_i;
    end
  end

  // low bits may belong to a fixed block; higher bits move only in page mode
  for (genvar i = 0; i < COL_W; i++) begin : g_mask
    if (i < MAX_FIXED_BITS) begin : g_lo
      assign mask_o[i] = cfg_q.page | (cfg_q.lg > LG_W'(i));
    end else begin : g_hi
      assign mask_o[i] = cfg_q.page;
    end
  end

  assign base_o = base_q;
  assign page_o = cfg_q.page;
  assign ilv_o  = cfg_q.ilv;

endmodule

// File: rtl/burst_beat_seq.sv
module burst_beat_seq #(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             ready_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             page_i,
  output logic             valid_o,
  output logic             last_o,
  output logic [COL_W-1:0] beat_o
);

  logic             valid_q;
  logic [COL_W-1:0] beat_q;
  logic             is_last;

  assign is_last = valid_q && !page_i && (beat_q == mask_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      beat_q  <= '0;
    end else if (start_i) begin
      valid_q <= 1'b1;
      beat_q  <= '0;
    end else if (stop_i) begin
      valid_q <= 1'b0;
    end else if (valid_q && ready_i) begin
      if (is_last) valid_q <= 1'b0;
      else         beat_q  <= beat_q + COL_W'(1);
    end
  end

  assign valid_o = valid_q;
  assign last_o  = is_last;
  assign beat_o  = beat_q;

endmodule

// File: rtl/burst_col_map.sv
module burst_col_map #(
  parameter int COL_W = 9
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o
);

  logic [COL_W-1:0] offset;

  always_comb begin
    offset = ilv_i ? (base_i ^ beat_i) : (base_i + beat_i);
    col_o  = (base_i & ~mask_i) | (offset & mask_i);
  end

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       len_code_i,
  input  logic             ilv_i,
  input  logic             stop_i,
  input  logic             col_ready_i,
  output logic             col_valid_o,
  output logic [COL_W-1:0] col_o,
  output logic             last_o
);

  logic [COL_W-1:0] base, mask, beat;
  logic             page, ilv;

  burst_cfg_reg #(.COL_W(COL_W)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (start_i),
    .col_i      (start_col_i),
    .len_code_i (len_code_i),
    .ilv_i      (ilv_i),
    .base_o     (base),
    .mask_o     (mask),
    .page_o     (page),
    .ilv_o      (ilv)
  );

  burst_beat_seq #(.COL_W(COL_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .stop_i  (stop_i),
    .ready_i (col_ready_i),
    .mask_i  (mask),
    .page_i  (page),
    .valid_o (col_valid_o),
    .last_o  (last_o),
    .beat_o  (beat)
  );

  burst_col_map #(.COL_W(COL_W)) u_map (
    .base_i (base),
    .beat_i (beat),
    .mask_i (mask),
    .ilv_i  (ilv),
    .col_o  (col_o)
  );

endmodule

// File: rtl/burst_col_chk.sv
module burst_col_chk #(
  parameter int COL_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [COL_W-1:0] start_col_i,
  input logic [2:0]       len_code_i,
  input logic             stop_i,
  input logic             col_ready_i,
  input logic             col_valid_o,
  input logic [COL_W-1:0] col_o,
  input logic             last_o
);

  localparam int BLK = 3;

  logic                 page_q;
  logic [COL_W-1:BLK]   hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= 1'b0;
      hi_q   <= '0;
    end else if (start_i) begin
      page_q <= (len_code_i == 3'd7);
      hi_q   <= start_col_i[COL_W-1:BLK];
    end
  end

  AST_START_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> col_valid_o && (col_o == $past(start_col_i)));  // R2

  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid_o && !page_q |-> col_o[COL_W-1:BLK] == hi_q);  // R4

  AST_PAGE_NO_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid_o && page_q |-> !last_o);  // R6

  AST_LAST_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> col_valid_o);  // R7

  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid_o && col_ready_i && last_o && !start_i |=> !col_valid_o);  // R7

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid_o && !col_ready_i && !start_i && !stop_i
      |=> col_valid_o && $stable(col_o) && $stable(last_o));  // R8

  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i && !start_i |=> !col_valid_o && !last_o);  // R9

endmodule

bind burst_col_gen burst_col_chk #(.COL_W(COL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .start_col_i (start_col_i),
  .len_code_i  (len_code_i),
  .stop_i      (stop_i),
  .col_ready_i (col_ready_i),
  .col_valid_o (col_valid_o),
  .col_o       (col_o),
  .last_o      (last_o)
);

// File: tb/tb_burst_col_gen.sv
module tb_burst_col_gen;

  localparam int COL_W = 9;
  localparam int NCOL  = 1 << COL_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [COL_W-1:0] start_col_i = '0;
  logic [2:0]       len_code_i = '0;
  logic             ilv_i = 1'b0;
  logic             stop_i = 1'b0;
  logic             col_ready_i = 1'b0;
  logic             col_valid_o;
  logic [COL_W-1:0] col_o;
  logic             last_o;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  burst_col_gen #(.COL_W(COL_W)) dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int bl_of(input int code);
    case (code)
      1: return 2;
      2: return 4;
      3: return 8;
      7: return NCOL;
      default: return 1;
    endcase
  endfunction

  function automatic int exp_col(input int s, input int code, input bit ilv, input int k);
    int bl, blk, off;
    bl = bl_of(code);
    if (code == 7) return (s + k) % NCOL;
    blk = s - (s % bl);
    off = s % bl;
    if (ilv) return blk + ((off ^ (k % bl)) % bl);
    return blk + ((off + k) % bl);
  endfunction

  // runs one burst; stall=1 applies periodic back-pressure
  task automatic run_burst(input int s, input int code, input bit ilv, input bit stall, input int page_beats);
    int n, idx, cyc;
    bit rdy, page;
    page = (code == 7);
    n = page ? page_beats : bl_of(code);
    @(negedge clk);
    start_i = 1'b1; start_col_i = COL_W'(s); len_code_i = 3'(code); ilv_i = ilv;
    stop_i = 1'b0; col_ready_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    idx = 0; cyc = 0;
    while (idx < n) begin
      // R4 R5 R6 beat address, R7 last flag, R8 stall hold
      chk(col_valid_o == 1'b1, "R2/R8 valid during burst", int'(col_valid_o), 1);
      chk(int'(col_o) == exp_col(s, code, ilv, idx),
          page ? "R6 page column" : (ilv ? "R5 interleaved column" : "R4 linear column"),
          int'(col_o), exp_col(s, code, ilv, idx));
      chk(last_o == (!page && idx == n - 1), "R7 last flag", int'(last_o),
          int'(!page && idx == n - 1));
      rdy = stall ? ((cyc % 3) != 1) : 1'b1;
      col_ready_i = rdy;
      @(negedge clk);
      cyc++;
      if (rdy) idx++;
    end
    col_ready_i = 1'b1;
    if (page) begin
      stop_i = 1'b1;
      @(negedge clk);
      stop_i = 1'b0;
      chk(col_valid_o == 1'b0, "R9 stop ends page burst", int'(col_valid_o), 0);
    end else begin
      chk(col_valid_o == 1'b0, "R7 idle after last beat", int'(col_valid_o), 0);
    end
  endtask

  initial begin
    #400000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(col_valid_o == 1'b0, "R1 valid after reset", int'(col_valid_o), 0);
    chk(last_o == 1'b0, "R1 last after reset", int'(last_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(col_valid_o == 1'b0, "R1 idle before start", int'(col_valid_o), 0);

    // R3 every length code, both orders, many start columns
    for (int code = 0; code < 8; code++)
      for (int t = 0; t < 2; t++)
        for (int si = 0; si < 18; si++)
          run_burst(si < 16 ? si : (si == 16 ? 9'h1F3 : 9'h1FF), code, t[0], si[0], 12);

    // R6 page wrap past the top column, interleave request ignored
    run_burst(509, 7, 1'b1, 1'b0, 600);

    // R9 stop in the middle of a fixed burst
    @(negedge clk);
    start_i = 1'b1; start_col_i = 9'h010; len_code_i = 3'd3; ilv_i = 1'b0; col_ready_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(int'(col_o) == 9'h012, "R4 mid-burst column", int'(col_o), 9'h012);
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    chk(col_valid_o == 1'b0, "R9 stop mid fixed burst", int'(col_valid_o), 0);
    chk(last_o == 1'b0, "R9 no last after stop", int'(last_o), 0);

    // R10 restart during an active burst, new interleaved burst of 4 at 0x45
    @(negedge clk);
    start_i = 1'b1; start_col_i = 9'h008; len_code_i = 3'd3; ilv_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    start_i = 1'b1; start_col_i = 9'h045; len_code_i = 3'd2; ilv_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < 4; k++) begin
      chk(int'(col_o) == exp_col(9'h045, 2, 1'b1, k), "R10 restart sequence",
          int'(col_o), exp_col(9'h045, 2, 1'b1, k));
      @(negedge clk);
    end
    chk(col_valid_o == 1'b0, "R10 restarted burst ends", int'(col_valid_o), 0);

    // R10 start and stop together: start wins
    start_i = 1'b1; stop_i = 1'b1; start_col_i = 9'h123; len_code_i = 3'd1; ilv_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0; stop_i = 1'b0;
    chk(col_valid_o == 1'b1, "R10 start beats stop", int'(col_valid_o), 1);
    chk(int'(col_o) == 9'h123, "R10 start column", int'(col_o), 9'h123);
    @(negedge clk);
    chk(int'(col_o) == 9'h122, "R4 wrap in 2-beat block", int'(col_o), 9'h122);
    @(negedge clk);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule